// File: doc/BRIEF.md
# Toggle-Poll Flash Sector Programmer

This block erases or programs one sector of a byte-wide flash device that only accepts commands after a two-write unlock prefix. It shows it is busy by flipping a status bit on every read. A single `start` pulse, with `op_prog` choosing program (1) or erase (0), launches a complete operation. The block sends the command writes with a fixed settle interval between flash accesses. It then polls the sector base with pairs of back-to-back reads until two reads agree. It writes a reset command, waits the settle interval, and reads the whole sector back to confirm the result.

For a program operation the bytes come from a source port. `src_addr` gives the sector offset of the byte wanted, and the data is expected on `src_data` in the same cycle. The flash port carries one access per cycle, a write or a read, and read data is sampled in the cycle of the read. When the operation ends, `done` pulses for one cycle and `err` holds the result code until the next start.

Top module: `flash_sector_prog`

## Requirements
- R1: After reset `busy`, `done`, `fl_we` and `fl_re` are 0 and `err` is 0. The flash port makes no access while `busy` is 0.
- R2: An erase writes exactly these six commands in order, as (address, data) with addresses relative to the sector base: (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x000,0x30).
- R3: Each byte i of a program, taken in ascending order from 0, is written as (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), then (i, source byte i). The next byte begins only after the previous one has completed.
- R4: At most one access, a read or a write, happens per cycle. Every access that follows a write is preceded by at least SETTLE_CYC cycles with no access.
- R5: After the last command write of a step, the block reads the sector base in back-to-back pairs. The step is complete at the first pair whose two values are equal.
- R6: If POLL_LIMIT pairs in a row differ, the operation stops at the current byte. The reset command is still written, no verify read is made, and `err` becomes 1 (timeout).
- R7: Every operation ends its flash activity with data 0xF0 written to the sector base, followed by SETTLE_CYC idle cycles before any further access.
- R8: After an erase, offsets 0 upward are read once each. Every byte must read 0xFF. The first mismatch ends the operation with `err` = 2 (verify); a full match gives `err` = 0.
- R9: After a program, every byte read back must equal the source byte at the same offset. The first mismatch ends the operation with `err` = 2; a full match gives `err` = 0.
- R10: `done` is a one-cycle pulse while `busy` is 1. `start` has no effect while `busy` is 1. `err` stays stable while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches an operation when idle |
| op_prog | input | 1 | 1 selects program, 0 selects erase; sampled with start |
| src_addr | output | SECT_AW | Offset of the source byte currently needed |
| src_data | input | 8 | Source byte at src_addr, same cycle |
| fl_addr | output | FL_AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid in the cycle of fl_re |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Result: 0 ok, 1 timeout, 2 verify mismatch |

## Verification
The checker watches the timing rules on every cycle. These are the idle quiet port, one access per cycle, the settle gap after each write, `done` as a single pulse inside `busy`, `err` held while idle, and the reset command as the last write before `done`. The exact command order, the number of poll reads for a given busy duration, the stop at the current byte on timeout, and the verify mismatch positions depend on what the flash returns. Only the bench's scenarios can show these, against a behavioural flash model that decodes the unlock sequence and toggles its status bit.

// File: rtl/flp_pkg.sv
package flp_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_GAP,
        S_POLL_A,
        S_POLL_B,
        S_RST,
        S_RST_GAP,
        S_VERIFY,
        S_DONE
    } state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_VERIFY  = 2'd2
    } err_e;

    // command offsets relative to sector base
    localparam logic [11:0] OFS_KEY1 = 12'h555;
    localparam logic [11:0] OFS_KEY2 = 12'h2AA;

    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_ERASE_A = 8'h80;
    localparam logic [7:0] CMD_ERASE_B = 8'h30;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] ERASED      = 8'hFF;

endpackage

// File: rtl/flp_cmd_rom.sv
module flp_cmd_rom #(
    parameter int FL_AW     = 13,
    parameter int SECT_BASE = 0
) (
    input  logic             op_prog,
    input  logic [2:0]       step,
    input  logic [FL_AW-1:0] tgt_addr,
    input  logic [7:0]       src_byte,
    output logic [FL_AW-1:0] cmd_addr,
    output logic [7:0]       cmd_data,
    output logic             cmd_last
);
    import flp_pkg::*;

    localparam logic [FL_AW-1:0] A_BASE = FL_AW'(SECT_BASE);
    localparam logic [FL_AW-1:0] A_KEY1 = A_BASE + FL_AW'(OFS_KEY1);
    localparam logic [FL_AW-1:0] A_KEY2 = A_BASE + FL_AW'(OFS_KEY2);

    always_comb begin
        cmd_addr = A_BASE;
        cmd_data = CMD_RESET;
        cmd_last = 1'b0;
        case (step)
            3'd0: begin cmd_addr = A_KEY1; cmd_data = CMD_KEY1; end
            3'd1: begin cmd_addr = A_KEY2; cmd_data = CMD_KEY2; end
            3'd2: begin
                cmd_addr = A_KEY1;
                cmd_data = op_prog ? CMD_PROG : CMD_ERASE_A;
            end
            3'd3: begin
                if (op_prog) begin
                    cmd_addr = tgt_addr;
                    cmd_data = src_byte;
                    cmd_last = 1'b1;
                end else begin
                    cmd_addr = A_KEY1;
                    cmd_data = CMD_KEY1;
                end
            end
            3'd4: begin cmd_addr = A_KEY2; cmd_data = CMD_KEY2; end
            3'd5: begin
                cmd_addr = A_BASE;
                cmd_data = CMD_ERASE_B;
                cmd_last = 1'b1;
            end
            default: begin
                cmd_addr = A_BASE;
                cmd_data = CMD_RESET;
                cmd_last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/flp_gap_timer.sv
module flp_gap_timer #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CW'(CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q <= CW'(1));

endmodule

// File: rtl/flp_poll_ctr.sv
module flp_poll_ctr #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_limit = (cnt_q >= CW'(LIMIT - 1));

endmodule

// File: rtl/flash_sector_prog.sv
module flash_sector_prog #(
    parameter int FL_AW      = 13,
    parameter int SECT_AW    = 13,
    parameter int SECT_BASE  = 0,
    parameter int SETTLE_CYC = 8,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               op_prog,
    output logic [SECT_AW-1:0] src_addr,
    input  logic [7:0]         src_data,
    output logic [FL_AW-1:0]   fl_addr,
    output logic [7:0]         fl_wdata,
    output logic               fl_we,
    output logic               fl_re,
    input  logic [7:0]         fl_rdata,
    output logic               busy,
    output logic               done,
    output logic [1:0]         err
);
    import flp_pkg::*;

    localparam logic [FL_AW-1:0] A_BASE = FL_AW'(SECT_BASE);

    typedef struct packed {
        state_e             st;
        logic               op;
        logic [SECT_AW-1:0] idx;
        logic [2:0]         step;
        logic [7:0]         first;
        err_e               err;
        logic               tmo;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: S_IDLE, op: 1'b0, idx: '0, step: '0,
        first: '0, err: ERR_NONE, tmo: 1'b0
    };

    regs_t r_d, r_q;

    logic             gap_load, gap_done;
    logic             poll_clr, poll_inc, poll_at_limit;
    logic [FL_AW-1:0] tgt_addr, rom_addr;
    logic [7:0]       rom_data, expect_byte;
    logic             rom_last, idx_last;

    assign tgt_addr    = A_BASE + FL_AW'(r_q.idx);
    assign idx_last    = &r_q.idx;
    assign expect_byte = r_q.op ? src_data : ERASED;

    flp_cmd_rom #(
        .FL_AW     (FL_AW),
        .SECT_BASE (SECT_BASE)
    ) u_rom (
        .op_prog  (r_q.op),
        .step     (r_q.step),
        .tgt_addr (tgt_addr),
        .src_byte (src_data),
        .cmd_addr (rom_addr),
        .cmd_data (rom_data),
        .cmd_last (rom_last)
    );

    flp_gap_timer #(
        .CYC (SETTLE_CYC)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_done)
    );

    flp_poll_ctr #(
        .LIMIT (POLL_LIMIT)
    ) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (poll_clr),
        .inc      (poll_inc),
        .at_limit (poll_at_limit)
    );

    always_comb begin
        r_d      = r_q;
        gap_load = 1'b0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_addr  = A_BASE;
        fl_wdata = '0;

        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.op   = op_prog;
                    r_d.idx  = '0;
                    r_d.step = '0;
                    r_d.err  = ERR_NONE;
                    r_d.tmo  = 1'b0;
                    r_d.st   = S_CMD;
                end
            end
            S_CMD: begin
                fl_we    = 1'b1;
                fl_addr  = rom_addr;
                fl_wdata = rom_data;
                gap_load = 1'b1;
                poll_clr = 1'b1;
                r_d.st   = S_GAP;
            end
            S_GAP: begin
                if (gap_done) begin
                    if (rom_last) begin
                        r_d.st = S_POLL_A;
                    end else begin
                        r_d.step = r_q.step + 3'd1;
                        r_d.st   = S_CMD;
                    end
                end
            end
            S_POLL_A: begin
                fl_re     = 1'b1;
                r_d.first = fl_rdata;
                r_d.st    = S_POLL_B;
            end
            S_POLL_B: begin
                fl_re = 1'b1;
                if (fl_rdata == r_q.first) begin
                    if (r_q.op && !idx_last) begin
                        r_d.idx  = r_q.idx + 1'b1;
                        r_d.step = '0;
                        r_d.st   = S_CMD;
                    end else begin
                        r_d.st = S_RST;
                    end
                end else if (poll_at_limit) begin
                    r_d.tmo = 1'b1;
                    r_d.st  = S_RST;
                end else begin
                    poll_inc = 1'b1;
                    r_d.st   = S_POLL_A;
                end
            end
            S_RST: begin
                fl_we    = 1'b1;
                fl_wdata = CMD_RESET;
                gap_load = 1'b1;
                r_d.st   = S_RST_GAP;
            end
            S_RST_GAP: begin
                if (gap_done) begin
                    if (r_q.tmo) begin
                        r_d.err = ERR_TIMEOUT;
                        r_d.st  = S_DONE;
                    end else begin
                        r_d.idx = '0;
                        r_d.st  = S_VERIFY;
                    end
                end
            end
            S_VERIFY: begin
                fl_re   = 1'b1;
                fl_addr = tgt_addr;
                if (fl_rdata != expect_byte) begin
                    r_d.err = ERR_VERIFY;
                    r_d.st  = S_DONE;
                end else if (idx_last) begin
                    r_d.st = S_DONE;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            S_DONE: begin
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign src_addr = r_q.idx;
    assign busy     = (r_q.st != S_IDLE);
    assign done     = (r_q.st == S_DONE);
    assign err      = r_q.err;

endmodule

// File: rtl/flp_chk.sv
module flp_chk #(
    parameter int SETTLE_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] err,
    input logic       fl_we,
    input logic       fl_re,
    input logic [7:0] fl_wdata
);
    localparam int GW = $clog2(SETTLE_CYC + 1);

    logic [GW-1:0] gap_q;
    logic [7:0]    last_wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q     <= GW'(SETTLE_CYC);
            last_wr_q <= '0;
        end else if (fl_we) begin
            gap_q     <= '0;
            last_wr_q <= fl_wdata;
        end else if (gap_q < GW'(SETTLE_CYC)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_we && !fl_re));

    p_one_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    p_settle_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we || fl_re) |-> (gap_q >= GW'(SETTLE_CYC)));

    p_reset_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (last_wr_q == 8'hF0));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(err));

endmodule

bind flash_sector_prog flp_chk #(
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .fl_we    (fl_we),
    .fl_re    (fl_re),
    .fl_wdata (fl_wdata)
);

// File: tb/sim_flash_sector_prog.sv
module sim_flash_sector_prog;

    localparam int CLK_PERIOD = 10;
    localparam int FL_AW      = 13;
    localparam int SECT_AW    = 6;
    localparam int NBYTES     = 1 << SECT_AW;
    localparam int SETTLE     = 3;
    localparam int PLIM       = 20;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               op_prog = 1'b0;
    logic [SECT_AW-1:0] src_addr;
    logic [7:0]         src_data;
    logic [FL_AW-1:0]   fl_addr;
    logic [7:0]         fl_wdata;
    logic               fl_we, fl_re;
    logic [7:0]         fl_rdata;
    logic               busy, done;
    logic [1:0]         err;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_sector_prog #(
        .FL_AW      (FL_AW),
        .SECT_AW    (SECT_AW),
        .SECT_BASE  (0),
        .SETTLE_CYC (SETTLE),
        .POLL_LIMIT (PLIM)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .op_prog (op_prog),
        .src_addr (src_addr), .src_data (src_data),
        .fl_addr (fl_addr), .fl_wdata (fl_wdata), .fl_we (fl_we),
        .fl_re (fl_re), .fl_rdata (fl_rdata),
        .busy (busy), .done (done), .err (err)
    );

    // ---------------- source and flash model ----------------
    logic [7:0] src_mem [NBYTES];
    logic [7:0] fmem    [NBYTES];
    int  busy_left, busy_cfg, stuck_busy, stuck_idx;
    logic tog;
    int  cs, perr, nreads, poll_snap, nlog, since_w, mingap;
    int  log_a [300];
    int  log_d [300];

    assign src_data = src_mem[src_addr];
    assign fl_rdata = (busy_left > 0) ? (tog ? 8'h6A : 8'h2A)
                                      : fmem[fl_addr[SECT_AW-1:0]];

    always @(posedge clk) begin
        if (fl_we || fl_re) begin
            if (since_w < mingap) mingap <= since_w;
        end
        if (fl_we) since_w <= 0;
        else if (since_w < 1000) since_w <= since_w + 1;

        if (fl_re) begin
            nreads <= nreads + 1;
            if (busy_left > 0) begin
                tog <= ~tog;
                if (!stuck_busy) busy_left <= busy_left - 1;
            end
        end
        if (fl_we) begin
            nreads <= 0;
            if (nlog < 300) begin
                log_a[nlog] <= int'(fl_addr);
                log_d[nlog] <= int'(fl_wdata);
            end
            nlog <= nlog + 1;
            if (fl_wdata == 8'hF0) begin
                cs <= 0;
                busy_left <= 0;
                poll_snap <= nreads;
            end else begin
                case (cs)
                    0: if (fl_addr == 13'h555 && fl_wdata == 8'hAA) cs <= 1;
                       else begin perr <= perr + 1; cs <= 0; end
                    1: if (fl_addr == 13'h2AA && fl_wdata == 8'h55) cs <= 2;
                       else begin perr <= perr + 1; cs <= 0; end
                    2: if (fl_addr == 13'h555 && fl_wdata == 8'h80) cs <= 3;
                       else if (fl_addr == 13'h555 && fl_wdata == 8'hA0) cs <= 10;
                       else begin perr <= perr + 1; cs <= 0; end
                    3: if (fl_addr == 13'h555 && fl_wdata == 8'hAA) cs <= 4;
                       else begin perr <= perr + 1; cs <= 0; end
                    4: if (fl_addr == 13'h2AA && fl_wdata == 8'h55) cs <= 5;
                       else begin perr <= perr + 1; cs <= 0; end
                    5: begin
                        if (fl_addr == 13'h000 && fl_wdata == 8'h30) begin
                            for (int i = 0; i < NBYTES; i++)
                                fmem[i] <= (i == stuck_idx) ? 8'h00 : 8'hFF;
                            busy_left <= stuck_busy ? 1 : busy_cfg;
                        end else perr <= perr + 1;
                        cs <= 0;
                    end
                    10: begin
                        fmem[fl_addr[SECT_AW-1:0]] <= fmem[fl_addr[SECT_AW-1:0]] & fl_wdata;
                        busy_left <= stuck_busy ? 1 : busy_cfg;
                        cs <= 0;
                    end
                    default: cs <= 0;
                endcase
            end
        end
    end

    // ---------------- checking helpers ----------------
    int nchk = 0, nerr = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        nlog = 0; perr = 0; cs = 0; busy_left = 0; tog = 1'b0;
        since_w = 1000; mingap = 1000; nreads = 0; poll_snap = -1;
        stuck_busy = 0; stuck_idx = -1;
    endtask

    task automatic fill_flash(input int v);
        for (int i = 0; i < NBYTES; i++) fmem[i] = v[7:0];
    endtask

    task automatic launch(input logic op);
        @(negedge clk);
        op_prog = op;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic wait_done(input string req, output int got_err);
        int n = 0;
        while (!done && n < 40000) begin
            @(negedge clk);
            n++;
        end
        got_err = int'(err);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL %s watchdog: actual 0 expected 1 (done)", req);
        end else begin
            @(negedge clk);
            chk("R10", "done pulse length", int'(done), 0);
        end
    endtask

    task automatic chk_wr(input string req, input int k, input int a, input int d);
        chk(req, $sformatf("write %0d addr", k), log_a[k], a);
        chk(req, $sformatf("write %0d data", k), log_d[k], d);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "err", int'(err), 0);
        chk("R1", "fl_we", int'(fl_we), 0);
        chk("R1", "fl_re", int'(fl_re), 0);
    endtask

    task automatic t_erase_ok();
        int e;
        clear_model();
        fill_flash(8'h3C);
        busy_cfg = 5;
        launch(1'b0);
        wait_done("R8", e);
        chk("R2", "write count", nlog, 7);
        chk_wr("R2", 0, 'h555, 'hAA);
        chk_wr("R2", 1, 'h2AA, 'h55);
        chk_wr("R2", 2, 'h555, 'h80);
        chk_wr("R2", 3, 'h555, 'hAA);
        chk_wr("R2", 4, 'h2AA, 'h55);
        chk_wr("R2", 5, 'h000, 'h30);
        chk_wr("R7", 6, 'h000, 'hF0);
        chk("R2", "protocol errors", perr, 0);
        chk("R5", "poll reads, 5 busy reads", poll_snap, 8);
        chk("R8", "err", e, 0);
        chk("R8", "verify reads", nreads, NBYTES);
        chk("R4", "min gap after write", mingap, SETTLE);
        chk("R1", "idle after done", int'(busy), 0);
    endtask

    task automatic t_program_ok();
        int e, bad;
        clear_model();
        fill_flash(8'hFF);
        for (int i = 0; i < NBYTES; i++) src_mem[i] = 8'(i * 7 + 3);
        busy_cfg = 3;
        launch(1'b1);
        wait_done("R9", e);
        chk("R3", "write count", nlog, 4 * NBYTES + 1);
        chk_wr("R3", 0, 'h555, 'hAA);
        chk_wr("R3", 1, 'h2AA, 'h55);
        chk_wr("R3", 2, 'h555, 'hA0);
        chk_wr("R3", 3, 0, 3);
        chk_wr("R3", 4 * (NBYTES - 1) + 2, 'h555, 'hA0);
        chk_wr("R3", 4 * (NBYTES - 1) + 3, NBYTES - 1, (7 * (NBYTES - 1) + 3) & 255);
        chk_wr("R7", 4 * NBYTES, 'h000, 'hF0);
        chk("R3", "protocol errors", perr, 0);
        chk("R5", "poll reads, 3 busy reads", poll_snap, 6);
        chk("R4", "min gap after write", mingap, SETTLE);
        chk("R9", "err", e, 0);
        chk("R9", "verify reads", nreads, NBYTES);
        bad = 0;
        for (int i = 0; i < NBYTES; i++) if (fmem[i] != src_mem[i]) bad++;
        chk("R9", "flash contents mismatches", bad, 0);
    endtask

    task automatic t_erase_verify_fail();
        int e;
        clear_model();
        fill_flash(8'h00);
        stuck_idx = 10;
        busy_cfg = 2;
        launch(1'b0);
        wait_done("R8", e);
        chk("R8", "err on stuck byte", e, 2);
        chk("R8", "verify reads up to mismatch", nreads, 11);
        chk("R5", "poll reads, 2 busy reads", poll_snap, 4);
    endtask

    task automatic t_program_verify_fail();
        int e;
        clear_model();
        fill_flash(8'hFF);
        fmem[5] = 8'h00;
        for (int i = 0; i < NBYTES; i++) src_mem[i] = 8'(i * 7 + 3);
        busy_cfg = 1;
        launch(1'b1);
        wait_done("R9", e);
        chk("R9", "err on unerased byte", e, 2);
        chk("R9", "verify reads up to mismatch", nreads, 6);
    endtask

    task automatic t_timeout();
        int e;
        clear_model();
        fill_flash(8'hFF);
        for (int i = 0; i < NBYTES; i++) src_mem[i] = 8'(i + 1);
        stuck_busy = 1;
        launch(1'b1);
        wait_done("R6", e);
        chk("R6", "err", e, 1);
        chk("R6", "writes: one byte then reset", nlog, 5);
        chk_wr("R7", 4, 'h000, 'hF0);
        chk("R6", "poll reads before reset", poll_snap, 2 * PLIM);
        chk("R6", "no verify reads", nreads, 0);
        chk("R6", "next byte untouched", int'(fmem[1]), 'hFF);
        repeat (5) @(negedge clk);
        chk("R10", "err held while idle", int'(err), 1);
    endtask

    task automatic t_start_ignored();
        int e;
        clear_model();
        fill_flash(8'h11);
        busy_cfg = 2;
        launch(1'b0);
        repeat (6) @(negedge clk);
        op_prog = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10", e);
        repeat (4) @(negedge clk);
        chk("R10", "no restart: busy", int'(busy), 0);
        chk("R10", "erase sequence only", nlog, 7);
        chk("R10", "err", e, 0);
    endtask

    initial begin
        clear_model();
        busy_cfg = 0;
        fill_flash(8'hFF);
        for (int i = 0; i < NBYTES; i++) src_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_erase_ok();
        t_program_ok();
        t_erase_verify_fail();
        t_program_verify_fail();
        t_timeout();
        t_start_ignored();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        nchk++; nerr++;
        $display("FAIL global watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule